// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that measures time against a free-running 64-bit system count supplied from outside. It does not count down. It keeps a 64-bit deadline (the compare value), and each refresh moves that deadline to the current count plus a programmable offset. If software misses the first deadline, a warning output rises and can serve as an interrupt. The deadline is then pushed out by one more offset period. If that second deadline also passes without a refresh, a reset request output rises. The reset request stays high until the block itself is reset, so software can find out after reboot that the watchdog caused the reset.

Software reaches the block through two simple register ports, one for each address frame. The control frame holds the enable and status word, the offset, the read-only deadline and an identification word. The refresh frame holds a single refresh register and its own copy of the identification word. Writing the control and status word also counts as a refresh. Clearing its enable bit stops both stages.

Top module: `wdt_two_stage`

## Requirements
- R1: Control-frame address 0x000 reads enable in bit 0, warning in bit 1 and reset request in bit 2, with all other bits zero. After reset all three are zero, and the pins `warn_o` and `rst_req_o` follow bits 1 and 2.
- R2: A write to control-frame address 0x000 loads enable from data bit 0 and also performs a refresh. Writing zero therefore stops the timer.
- R3: A write of any data to refresh-frame address 0x000 performs a refresh. A refresh sets the deadline to the count plus the offset and clears the warning, and this is visible one cycle after the write.
- R4: While enabled with the warning clear, a count at or above the deadline raises the warning on the next edge and moves the deadline to that count plus the offset.
- R5: While enabled with the warning set, a count at or above the deadline raises the reset request. The reset request holds through refreshes and disable, and only a block reset clears it.
- R6: While enable is clear, neither the warning nor the reset request can rise, whatever the count.
- R7: The 64-bit deadline reads at control-frame address 0x010 (bits 31:0) and 0x014 (bits 63:32).
- R8: The offset low word is at control-frame address 0x008. With VERSION=1 the offset is 48 bits: address 0x00C holds bits 47:32 in its data bits 15:0, and bits 31:16 of that word read zero and ignore writes. With VERSION=0 address 0x00C reads zero and ignores writes.
- R9: Address 0xFCC in both frames reads an identification word that carries VERSION in bits 19:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Free-running system count |
| ctl_wr | input | 1 | Control-frame write strobe |
| ctl_addr | input | 12 | Control-frame byte address |
| ctl_wdata | input | 32 | Control-frame write data |
| ctl_rdata | output | 32 | Control-frame read data (combinational) |
| rfr_wr | input | 1 | Refresh-frame write strobe |
| rfr_addr | input | 12 | Refresh-frame byte address |
| rfr_wdata | input | 32 | Refresh-frame write data (value ignored) |
| rfr_rdata | output | 32 | Refresh-frame read data (combinational) |
| warn_o | output | 1 | First-stage warning |
| rst_req_o | output | 1 | Second-stage reset request |

## Verification
The bench builds the block with VERSION=1, so the 48-bit offset is in use and the masking of bits 31:16 of the upper offset word can be tested. Counts are placed just below and just above the 32-bit boundary. This shows that the deadline sum carries into the upper word and that the compare covers all 64 bits. The table drives the full sequence of warning, refresh, second warning and sticky reset request, with the count one below the deadline and then exactly on it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned COUNT_W = 64;

    localparam logic [ADDR_W-1:0] A_CS      = 12'h000;
    localparam logic [ADDR_W-1:0] A_OFS_LO  = 12'h008;
    localparam logic [ADDR_W-1:0] A_OFS_HI  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h010;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h014;
    localparam logic [ADDR_W-1:0] A_ID      = 12'hFCC;
    localparam logic [ADDR_W-1:0] A_REFRESH = 12'h000;

    // packed order puts en at bit 0, warn at bit 1, rst at bit 2
    typedef struct packed {
        logic rst;
        logic warn;
        logic en;
    } wdt_status_t;

    function automatic logic [DATA_W-1:0] id_word(input int unsigned ver,
                                                  input int unsigned impl);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[19:16] = 4'(ver);
        w[11:0]  = 12'(impl);
        return w;
    endfunction

    function automatic logic [15:0] hi_mask(input int unsigned ver);
        return (ver == 0) ? 16'h0000 : 16'hFFFF;
    endfunction
endpackage

// File: rtl/wdt_offset_reg.sv
module wdt_offset_reg
    import wdt_pkg::*;
#(
    parameter int unsigned VERSION = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [COUNT_W-1:0]  ofs,
    output logic [DATA_W-1:0]   rd_lo,
    output logic [DATA_W-1:0]   rd_hi
);
    localparam logic [15:0] HI_MASK = hi_mask(VERSION);

    logic [DATA_W-1:0] lo_q;
    logic [15:0]       hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata[15:0] & HI_MASK;
        end
    end

    assign ofs   = {16'h0000, hi_q, lo_q};
    assign rd_lo = lo_q;
    assign rd_hi = {16'h0000, hi_q};
endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
    import wdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               refresh,
    input  logic [COUNT_W-1:0] count,
    input  logic [COUNT_W-1:0] ofs,
    output logic [COUNT_W-1:0] cmp,
    output logic               warn,
    output logic               rst_req
);
    logic [COUNT_W-1:0] next_deadline;
    logic               expired;

    assign next_deadline = count + ofs;
    assign expired       = en && (count >= cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp     <= '0;
            warn    <= 1'b0;
            rst_req <= 1'b0;
        end else if (refresh) begin
            cmp  <= next_deadline;
            warn <= 1'b0;
        end else if (expired) begin
            if (!warn) begin
                warn <= 1'b1;
                cmp  <= next_deadline;
            end else begin
                rst_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int unsigned VERSION   = 1,
    parameter int unsigned IMPL_CODE = 12'h5A1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [63:0]        sys_count,
    input  logic               ctl_wr,
    input  logic [11:0]        ctl_addr,
    input  logic [31:0]        ctl_wdata,
    output logic [31:0]        ctl_rdata,
    input  logic               rfr_wr,
    input  logic [11:0]        rfr_addr,
    input  logic [31:0]        rfr_wdata,
    output logic [31:0]        rfr_rdata,
    output logic               warn_o,
    output logic               rst_req_o
);
    localparam logic [DATA_W-1:0] ID_VAL = id_word(VERSION, IMPL_CODE);

    logic               en_q;
    logic               cs_wr;
    logic               refresh;
    logic [COUNT_W-1:0] ofs64;
    logic [DATA_W-1:0]  ofs_rd_lo;
    logic [DATA_W-1:0]  ofs_rd_hi;
    logic [COUNT_W-1:0] cmp;
    wdt_status_t        status;
    logic               unused_rfr_data;

    assign unused_rfr_data = ^rfr_wdata;

    assign cs_wr   = ctl_wr && (ctl_addr == A_CS);
    assign refresh = cs_wr || (rfr_wr && (rfr_addr == A_REFRESH));

    always_ff @(posedge clk) begin
        if (rst)        en_q <= 1'b0;
        else if (cs_wr) en_q <= ctl_wdata[0];
    end

    wdt_offset_reg #(.VERSION(VERSION)) u_ofs (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (ctl_wr && (ctl_addr == A_OFS_LO)),
        .wr_hi (ctl_wr && (ctl_addr == A_OFS_HI)),
        .wdata (ctl_wdata),
        .ofs   (ofs64),
        .rd_lo (ofs_rd_lo),
        .rd_hi (ofs_rd_hi)
    );

    wdt_stage_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .refresh (refresh),
        .count   (sys_count),
        .ofs     (ofs64),
        .cmp     (cmp),
        .warn    (warn_o),
        .rst_req (rst_req_o)
    );

    assign status = '{rst: rst_req_o, warn: warn_o, en: en_q};

    always_comb begin
        case (ctl_addr)
            A_CS:     ctl_rdata = {29'h0, status};
            A_OFS_LO: ctl_rdata = ofs_rd_lo;
            A_OFS_HI: ctl_rdata = ofs_rd_hi;
            A_CMP_LO: ctl_rdata = cmp[31:0];
            A_CMP_HI: ctl_rdata = cmp[63:32];
            A_ID:     ctl_rdata = ID_VAL;
            default:  ctl_rdata = '0;
        endcase
    end

    assign rfr_rdata = (rfr_addr == A_ID) ? ID_VAL : '0;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
    input logic        clk,
    input logic        rst,
    input logic        en_q,
    input logic        refresh,
    input logic        warn_o,
    input logic        rst_req_o,
    input logic [63:0] sys_count,
    input logic [63:0] ofs64,
    input logic [63:0] cmp
);
    AST_RELOAD_ON_REFRESH: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (cmp == $past(sys_count) + $past(ofs64))); // R3

    AST_WARN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        refresh |=> !warn_o); // R3

    AST_RESET_STICKY: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o); // R5

    AST_RESET_AFTER_WARN: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> warn_o); // R5

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !refresh) |=> (!$rose(warn_o) && !$rose(rst_req_o))); // R6
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .refresh   (refresh),
    .warn_o    (warn_o),
    .rst_req_o (rst_req_o),
    .sys_count (sys_count),
    .ofs64     (ofs64),
    .cmp       (cmp)
);

// File: tb/wdt_two_stage_bench.sv
`timescale 1ns/1ps
module wdt_two_stage_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_count = '0;
    logic        ctl_wr = 1'b0;
    logic [11:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        rfr_wr = 1'b0;
    logic [11:0] rfr_addr = '0;
    logic [31:0] rfr_wdata = '0;
    logic [31:0] rfr_rdata;
    logic        warn_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdt_two_stage #(.VERSION(1)) u_wdt_two_stage (
        .clk(clk), .rst(rst), .sys_count(sys_count),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rfr_wr(rfr_wr), .rfr_addr(rfr_addr), .rfr_wdata(rfr_wdata), .rfr_rdata(rfr_rdata),
        .warn_o(warn_o), .rst_req_o(rst_req_o)
    );

    // op: 0 idle, 1 control write, 2 refresh write; exp = {rst, warn, en}
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [63:0] cnt;
        logic [2:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 12'h008, 32'd100,         64'd0,    3'b000}, // R8 offset 100
        '{2'd1, 12'h000, 32'd1,           64'd1000, 3'b001}, // R2 enable, deadline 1100
        '{2'd0, 12'h000, 32'd0,           64'd1099, 3'b001}, // R4 one below
        '{2'd0, 12'h000, 32'd0,           64'd1100, 3'b011}, // R4 warning, deadline 1200
        '{2'd0, 12'h000, 32'd0,           64'd1199, 3'b011}, // R5 one below
        '{2'd2, 12'h000, 32'hA5A5_0000,   64'd1150, 3'b001}, // R3 refresh, deadline 1250
        '{2'd0, 12'h000, 32'd0,           64'd1249, 3'b001}, // R4
        '{2'd0, 12'h000, 32'd0,           64'd1250, 3'b011}, // R4 deadline 1350
        '{2'd0, 12'h000, 32'd0,           64'd1349, 3'b011}, // R5
        '{2'd0, 12'h000, 32'd0,           64'd1350, 3'b111}, // R5 reset request
        '{2'd1, 12'h000, 32'd0,           64'd1400, 3'b100}, // R2 stop, R5 sticky
        '{2'd0, 12'h000, 32'd0,           64'd9999, 3'b100}  // R5 sticky
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [11:0] a,
                        input logic [31:0] d, input logic [63:0] c);
        @(negedge clk);
        ctl_wr    = (op == 2'd1);
        rfr_wr    = (op == 2'd2);
        ctl_addr  = a;
        rfr_addr  = 12'h000;
        ctl_wdata = d;
        rfr_wdata = d;
        sys_count = c;
        @(negedge clk);
        ctl_wr = 1'b0;
        rfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        ctl_addr = a;
        #1;
        v = ctl_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].cnt);
            rd(12'h000, v);
            check($sformatf("R1 table step %0d status", i), {32'h0, v}, {61'h0, VECS[i].exp});
            check($sformatf("R1 table step %0d pins", i), {62'h0, rst_req_o, warn_o},
                  {62'h0, VECS[i].exp[2:1]});
        end

        // block reset clears the sticky request (R5) and gives zero status (R1)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(12'h000, v);
        check("R5 R1 status after reset", {32'h0, v}, 64'h0);
        check("R1 pins after reset", {62'h0, rst_req_o, warn_o}, 64'h0);

        // identification in both frames (R9)
        rd(12'hFCC, v);
        check("R9 control id version", {60'h0, v[19:16]}, 64'h1);
        rfr_addr = 12'hFCC; #1;
        check("R9 refresh id version", {60'h0, rfr_rdata[19:16]}, 64'h1);
        rfr_addr = 12'h000;

        // offset width and masking (R8)
        step(2'd1, 12'h008, 32'h1234_5678, 64'd0);
        step(2'd1, 12'h00C, 32'hFFFF_ABCD, 64'd0);
        rd(12'h008, v);
        check("R8 offset low", {32'h0, v}, 64'h1234_5678);
        rd(12'h00C, v);
        check("R8 offset high masked", {32'h0, v}, 64'h0000_ABCD);

        // disabled: refresh loads deadline but no stage fires (R6, R3, R7)
        step(2'd1, 12'h00C, 32'h0, 64'd0);
        step(2'd1, 12'h008, 32'd10, 64'd0);
        step(2'd2, 12'h000, 32'h0, 64'd1000);
        rd(12'h010, v);
        check("R7 R3 deadline while disabled", {32'h0, v}, 64'd1010);
        step(2'd0, 12'h000, 32'h0, 64'd5000);
        step(2'd0, 12'h000, 32'h0, 64'd6000);
        check("R6 no stage while disabled", {62'h0, rst_req_o, warn_o}, 64'h0);

        // deadline crossing 32-bit boundary (R7, R2)
        step(2'd1, 12'h000, 32'h1, 64'h0000_0000_FFFF_FFFA);
        rd(12'h010, v);
        check("R7 deadline low word", {32'h0, v}, 64'h4);
        rd(12'h014, v);
        check("R7 deadline high word", {32'h0, v}, 64'h1);
        rd(12'h000, v);
        check("R2 enabled status", {32'h0, v}, 64'h1);

        // refresh with all-ones data still refreshes (R3)
        step(2'd2, 12'h000, 32'hFFFF_FFFF, 64'h0000_0001_0000_0000);
        rd(12'h010, v);
        check("R3 refresh any data", {32'h0, v}, 64'hA);

        // full compare width: count above deadline in upper word fires warning (R4)
        step(2'd0, 12'h000, 32'h0, 64'h0000_0001_0000_000A);
        check("R4 warning at 64-bit deadline", {63'h0, warn_o}, 64'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule